// File: doc/BRIEF.md
# Mode-Register Command Launch Unit

This unit lets software send single commands to a low-power DDR3 memory during bring-up. Software writes a control word that holds a mode selector, a 6-bit mode-register address, a calibration type and an 8-bit data byte. Writing that word only arms the command. The command is issued when the next write access arrives anywhere in the memory address window, and the data of that write is discarded. The unit then holds one encoded command on its command interface until the interface answers with a done handshake. When the command is a mode-register read, the returned byte is stored into readable status fields.

The unit also tracks power-up. The first NOP after reset turns on the memory clock enable. The second NOP raises CKE. In normal mode (mode 0) no command is armed, and memory writes pass straight through to a registered pass-through port.

Top module: `mr_cmd_launch`

## Requirements
- R1: After reset, cmd_valid, clk_en, cke and pt_wr are 0. Register offsets 0 to 3 all read 0, and the unit is in normal mode.
- R2: A control write to offset 0 stores mode in bits [2:0], mode-register address in [9:4], calibration type in [13:12] and data byte in [23:16]. Reading offset 0 returns exactly those fields while the command stays armed. Offset 1 reads busy at bit 0, armed at bit 1, clk_en at bit 2 and cke at bit 3. Register reads return data one cycle after reg_rd.
- R3: Mode 1 or mode 7 arms a command, and cmd_valid stays low until a memory write arrives. The first memory write (mem_wr) launches the command. cmd_valid rises one cycle later, and the write data is neither used nor passed through.
- R4: The command codes on cmd_op are as follows. Mode 1 gives NOP=1. Mode 7 with address 63 gives RESET=4 and cmd_arg=0. Mode 7 with address 10 gives ZQCAL=5, with the calibration type in cmd_arg[1:0]. Mode 7 with address 0 or 4 to 8 gives MRR=3 and cmd_arg=0. Mode 7 with any other address gives MRW=2, with the data byte in cmd_arg. cmd_ma carries the address.
- R5: The first launched NOP after reset sets clk_en. The second launched NOP sets cke. Both then stay set.
- R6: cmd_valid and its op, address and argument stay stable until cmd_done is sampled high. cmd_valid drops on that edge, together with busy.
- R7: When an MRR completes, the byte on rd_data is stored according to its address. Address 5 goes to offset 2 bits [7:0], address 6 to bits [15:8] and address 8 to bits [23:16].
- R8: When an MRR of address 0 completes, offset 3 bit 0 takes rd_data[0] (DAI) and offset 3 bits [2:1] take rd_data[4:3] (RZQI).
- R9: A control write is ignored while busy, or in the same cycle as a launching memory write. A memory write while busy neither launches a command nor passes through.
- R10: In mode 0 a memory write is passed through. pt_wr, pt_addr and pt_wdata are valid one cycle later, for one cycle. Writing mode 0 cancels any armed command.
- R11: Modes other than 0, 1 and 7 arm nothing. Memory writes in those modes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| mem_wr | input | 1 | Write access in the memory window |
| mem_addr | input | ADDR_W | Write address |
| mem_wdata | input | DATA_W | Write data |
| pt_wr | output | 1 | Pass-through write strobe |
| pt_addr | output | ADDR_W | Pass-through address |
| pt_wdata | output | DATA_W | Pass-through data |
| cmd_valid | output | 1 | Command held for the command interface |
| cmd_op | output | 3 | Command code |
| cmd_ma | output | 6 | Mode-register address |
| cmd_arg | output | 8 | Write byte or calibration type |
| cmd_done | input | 1 | Command completion handshake |
| rd_data | input | 8 | Mode-register read byte, valid with cmd_done |
| clk_en | output | 1 | Memory clock enable |
| cke | output | 1 | Memory CKE |

## Verification
The bench targets the boundary addresses of the decode: 63, 10, 0, 4, 8 and the neighbours 3 and 9. A wrong comparison there would send an MRW where a reset, calibration or read was meant. It checks that a memory write during busy, or a control write during busy, changes nothing. A unit that re-launched or overwrote the stored word would show a second command or altered readback. It counts NOPs across clk_en and cke, drops mode 0 and an unsupported mode on an armed command, and checks that random MRR bytes land only in the field their address selects.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_NOP   = 3'd1,
    OP_MRW   = 3'd2,
    OP_MRR   = 3'd3,
    OP_RESET = 3'd4,
    OP_ZQCAL = 3'd5
  } mr_op_e;

  localparam logic [2:0] MODE_NORMAL = 3'd0;
  localparam logic [2:0] MODE_NOP    = 3'd1;
  localparam logic [2:0] MODE_LPCMD  = 3'd7;
  localparam logic [5:0] MA_RESET    = 6'd63;
  localparam logic [5:0] MA_ZQ       = 6'd10;
  localparam logic [5:0] MA_INFO     = 6'd0;

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] zq;
    logic [5:0] ma;
    logic [2:0] mode;
  } ctrl_t;

  function automatic ctrl_t word_to_ctrl(input logic [31:0] w);
    ctrl_t c;
    c.mode = w[2:0];
    c.ma   = w[9:4];
    c.zq   = w[13:12];
    c.data = w[23:16];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[2:0]   = c.mode;
    w[9:4]   = c.ma;
    w[13:12] = c.zq;
    w[23:16] = c.data;
    return w;
  endfunction
endpackage

// File: rtl/mrl_cmd_encode.sv
module mrl_cmd_encode
  import mrl_pkg::*;
#(
  parameter int RO_LO = 4,
  parameter int RO_HI = 8
) (
  input  ctrl_t      ctrl,
  output mr_op_e     op,
  output logic [7:0] arg
);
  localparam logic [5:0] LO = 6'(RO_LO);
  localparam logic [5:0] HI = 6'(RO_HI);

  always_comb begin
    op  = OP_IDLE;
    arg = '0;
    if (ctrl.mode == MODE_NOP) begin
      op = OP_NOP;
    end else if (ctrl.mode == MODE_LPCMD) begin
      if (ctrl.ma == MA_RESET) begin
        op = OP_RESET;
      end else if (ctrl.ma == MA_ZQ) begin
        op  = OP_ZQCAL;
        arg = {6'd0, ctrl.zq};
      end else if (ctrl.ma == MA_INFO || (ctrl.ma >= LO && ctrl.ma <= HI)) begin
        op = OP_MRR;
      end else begin
        op  = OP_MRW;
        arg = ctrl.data;
      end
    end
  end
endmodule

// File: rtl/mrl_ctrl_regs.sv
module mrl_ctrl_regs
  import mrl_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  input  logic          lock,
  input  logic          busy,
  input  logic          armed,
  input  logic          clk_en,
  input  logic          cke,
  input  logic [23:0]   dev_id,
  input  logic [2:0]    dev_info,
  output ctrl_t         ctrl,
  output logic          ctrl_wr,
  output logic [2:0]    wr_mode,
  output logic [RW-1:0] reg_rdata
);
  ctrl_t wr_ctrl;

  assign wr_ctrl = word_to_ctrl(reg_wdata[31:0]);
  assign ctrl_wr = reg_wr && (reg_addr == 2'd0) && !lock;
  assign wr_mode = wr_ctrl.mode;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (ctrl_wr) begin
      ctrl <= wr_ctrl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      unique case (reg_addr)
        2'd0: reg_rdata <= RW'(ctrl_to_word(ctrl));
        2'd1: reg_rdata <= RW'({cke, clk_en, armed, busy});
        2'd2: reg_rdata <= RW'(dev_id);
        default: reg_rdata <= RW'(dev_info);
      endcase
    end
  end

  a_r9_busy_holds_ctrl: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr) |=> $stable(ctrl));
endmodule

// File: rtl/mrl_launch_fsm.sv
module mrl_launch_fsm
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic              ctrl_wr,
  input  logic [2:0]        wr_mode,
  input  mr_op_e            op,
  input  logic [7:0]        arg,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic              cmd_done,
  output logic              lock,
  output logic              armed,
  output logic              cmd_valid,
  output mr_op_e            cmd_op,
  output logic [5:0]        cmd_ma,
  output logic [7:0]        cmd_arg,
  output logic              clk_en,
  output logic              cke,
  output logic              pt_wr,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [DATA_W-1:0] pt_wdata
);
  logic launch;

  assign launch = armed && mem_wr && !cmd_valid;
  assign lock   = cmd_valid || launch;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_op    <= OP_IDLE;
      cmd_ma    <= '0;
      cmd_arg   <= '0;
      clk_en    <= 1'b0;
      cke       <= 1'b0;
      pt_wr     <= 1'b0;
      pt_addr   <= '0;
      pt_wdata  <= '0;
    end else begin
      pt_wr <= 1'b0;
      if (cmd_valid) begin
        if (cmd_done) cmd_valid <= 1'b0;
      end else if (launch) begin
        cmd_valid <= 1'b1;
        armed     <= 1'b0;
        cmd_op    <= op;
        cmd_ma    <= ctrl.ma;
        cmd_arg   <= arg;
        if (op == OP_NOP) begin
          if (!clk_en) clk_en <= 1'b1;
          else         cke    <= 1'b1;
        end
      end else if (mem_wr && ctrl.mode == MODE_NORMAL) begin
        pt_wr    <= 1'b1;
        pt_addr  <= mem_addr;
        pt_wdata <= mem_wdata;
      end
      if (ctrl_wr) armed <= (wr_mode == MODE_NOP) || (wr_mode == MODE_LPCMD);
    end
  end

  a_r6_cmd_held: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_ma) && $stable(cmd_arg)));
  a_r3_launch_disarms: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> !armed);
  a_r5_cke_after_clk: assert property (@(posedge clk) disable iff (rst)
    cke |-> clk_en);
  a_r10_pt_not_with_cmd: assert property (@(posedge clk) disable iff (rst)
    pt_wr |-> !$rose(cmd_valid));
endmodule

// File: rtl/mrl_readback.sv
module mrl_readback
  import mrl_pkg::*;
#(
  parameter int MA_MFR = 5,
  parameter int MA_REV = 6,
  parameter int MA_ORG = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        capture,
  input  logic [5:0]  ma,
  input  logic [7:0]  rd_data,
  output logic [23:0] dev_id,
  output logic [2:0]  dev_info
);
  localparam int NB = 3;
  localparam logic [NB*6-1:0] SEL = {6'(MA_ORG), 6'(MA_REV), 6'(MA_MFR)};

  for (genvar g = 0; g < NB; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) dev_id[g*8 +: 8] <= '0;
      else if (capture && ma == SEL[g*6 +: 6]) dev_id[g*8 +: 8] <= rd_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dev_info <= '0;
    else if (capture && ma == MA_INFO) dev_info <= {rd_data[4:3], rd_data[0]};
  end

  a_r7_mfr_capture: assert property (@(posedge clk) disable iff (rst)
    (capture && ma == 6'(MA_MFR)) |=> (dev_id[7:0] == $past(rd_data)));
  a_r8_info_capture: assert property (@(posedge clk) disable iff (rst)
    (capture && ma == MA_INFO) |=> (dev_info == {$past(rd_data[4:3]), $past(rd_data[0])}));
endmodule

// File: rtl/mr_cmd_launch.sv
module mr_cmd_launch
  import mrl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              mem_wr,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              pt_wr,
  output logic [ADDR_W-1:0] pt_addr,
  output logic [DATA_W-1:0] pt_wdata,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [5:0]        cmd_ma,
  output logic [7:0]        cmd_arg,
  input  logic              cmd_done,
  input  logic [7:0]        rd_data,
  output logic              clk_en,
  output logic              cke
);
  ctrl_t       ctrl;
  logic        ctrl_wr, lock, armed;
  logic [2:0]  wr_mode;
  mr_op_e      enc_op, op_q;
  logic [7:0]  enc_arg;
  logic [23:0] dev_id;
  logic [2:0]  dev_info;

  assign cmd_op = op_q;

  mrl_ctrl_regs #(.RW(32)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lock(lock), .busy(cmd_valid), .armed(armed),
    .clk_en(clk_en), .cke(cke), .dev_id(dev_id), .dev_info(dev_info),
    .ctrl(ctrl), .ctrl_wr(ctrl_wr), .wr_mode(wr_mode), .reg_rdata(reg_rdata)
  );

  mrl_cmd_encode u_enc (.ctrl(ctrl), .op(enc_op), .arg(enc_arg));

  mrl_launch_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .ctrl(ctrl), .ctrl_wr(ctrl_wr), .wr_mode(wr_mode),
    .op(enc_op), .arg(enc_arg), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .cmd_done(cmd_done), .lock(lock), .armed(armed),
    .cmd_valid(cmd_valid), .cmd_op(op_q), .cmd_ma(cmd_ma), .cmd_arg(cmd_arg),
    .clk_en(clk_en), .cke(cke), .pt_wr(pt_wr), .pt_addr(pt_addr), .pt_wdata(pt_wdata)
  );

  mrl_readback u_rb (
    .clk(clk), .rst(rst), .capture(cmd_valid && cmd_done && op_q == OP_MRR),
    .ma(cmd_ma), .rd_data(rd_data), .dev_id(dev_id), .dev_info(dev_info)
  );
endmodule

// File: tb/test_mr_cmd_launch.sv
module test_mr_cmd_launch;
  localparam int AW = 32;
  localparam int DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, mem_wr = 0, cmd_done = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [AW-1:0] mem_addr = 0, pt_addr;
  logic [DW-1:0] mem_wdata = 0, pt_wdata;
  logic [7:0] rd_data = 0, cmd_arg;
  logic pt_wr, cmd_valid, clk_en, cke;
  logic [2:0] cmd_op;
  logic [5:0] cmd_ma;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] m_mfr = 0, m_rev = 0, m_org = 0;
  logic [2:0] m_info = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  mr_cmd_launch #(.ADDR_W(AW), .DATA_W(DW)) i_mr_cmd_launch (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .pt_wr(pt_wr), .pt_addr(pt_addr), .pt_wdata(pt_wdata),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_ma(cmd_ma), .cmd_arg(cmd_arg),
    .cmd_done(cmd_done), .rd_data(rd_data), .clk_en(clk_en), .cke(cke)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input logic [2:0] mode, input logic [5:0] ma,
                                     input logic [1:0] zq, input logic [7:0] d);
    return {8'd0, d, 2'd0, zq, 2'd0, ma, 1'b0, mode};
  endfunction

  function automatic logic [2:0] exp_op(input logic [2:0] mode, input logic [5:0] ma);
    if (mode == 3'd1) return 3'd1;
    if (mode != 3'd7) return 3'd0;
    if (ma == 6'd63) return 3'd4;
    if (ma == 6'd10) return 3'd5;
    if (ma == 6'd0 || (ma >= 6'd4 && ma <= 6'd8)) return 3'd3;
    return 3'd2;
  endfunction

  function automatic logic [7:0] exp_arg(input logic [2:0] mode, input logic [5:0] ma,
                                         input logic [1:0] zq, input logic [7:0] d);
    logic [2:0] o;
    o = exp_op(mode, ma);
    if (o == 3'd5) return {6'd0, zq};
    if (o == 3'd2) return d;
    return 8'd0;
  endfunction

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic mem_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    mem_wr = 1; mem_addr = a; mem_wdata = d;
    @(negedge clk); mem_wr = 0;
  endtask

  task automatic finish_cmd(input logic [7:0] d);
    cmd_done = 1; rd_data = d;
    @(negedge clk); cmd_done = 0; rd_data = 8'hEE;
  endtask

  task automatic run_cmd(input logic [2:0] mode, input logic [5:0] ma, input logic [1:0] zq,
                         input logic [7:0] d, input logic [7:0] rb, input string req);
    logic [2:0] eo;
    eo = exp_op(mode, ma);
    reg_write(2'd0, cw(mode, ma, zq, d));
    mem_write(32'h4000_0000 + 32'(ma), 32'hDEAD_0000 | 32'(d));
    chk(req, {29'd0, cmd_valid, pt_wr, 1'b0}, 32'h4);
    chk(req, 32'(cmd_op), 32'(eo));
    chk(req, 32'(cmd_ma), 32'(ma));
    chk(req, 32'(cmd_arg), 32'(exp_arg(mode, ma, zq, d)));
    finish_cmd(rb);
    if (eo == 3'd3) begin
      if (ma == 6'd5) m_mfr = rb;
      if (ma == 6'd6) m_rev = rb;
      if (ma == 6'd8) m_org = rb;
      if (ma == 6'd0) m_info = {rb[4:3], rb[0]};
    end
  endtask

  task automatic check_dev(input string req);
    logic [31:0] v;
    reg_read(2'd2, v); chk(req, v, {8'd0, m_org, m_rev, m_mfr});
    reg_read(2'd3, v); chk(req, v, {29'd0, m_info});
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {28'd0, cmd_valid, clk_en, cke, pt_wr}, 32'd0);
    for (int i = 0; i < 4; i++) begin
      reg_read(2'(i), rv); chk("R1", rv, 32'd0);
    end
    // R10 pass-through in normal mode
    mem_write(32'h1234_5678, 32'hCAFE_F00D);
    chk("R10", {31'd0, pt_wr}, 32'd1);
    chk("R10", pt_addr, 32'h1234_5678);
    chk("R10", pt_wdata, 32'hCAFE_F00D);
    chk("R3", {31'd0, cmd_valid}, 32'd0);
    @(negedge clk);
    chk("R10", {31'd0, pt_wr}, 32'd0);
    // R2 readback while armed, R3 no launch without memory write
    reg_write(2'd0, cw(3'd1, 6'd22, 2'd1, 8'hA5));
    repeat (3) @(negedge clk);
    chk("R3", {31'd0, cmd_valid}, 32'd0);
    reg_read(2'd0, rv); chk("R2", rv, cw(3'd1, 6'd22, 2'd1, 8'hA5));
    reg_read(2'd1, rv); chk("R2", rv, 32'h2);
    // R3 launch, R4 NOP, R5 clk_en
    mem_write(32'h0, 32'hFFFF_FFFF);
    chk("R3", {30'd0, cmd_valid, pt_wr}, 32'h2);
    chk("R4", 32'(cmd_op), 32'd1);
    chk("R5", {30'd0, clk_en, cke}, 32'h2);
    // R9 writes during busy ignored
    reg_write(2'd0, cw(3'd7, 6'd2, 2'd0, 8'h33));
    mem_write(32'h8, 32'h8);
    chk("R9", {30'd0, cmd_valid, pt_wr}, 32'h2);
    chk("R6", 32'(cmd_op), 32'd1);
    repeat (4) @(negedge clk);
    chk("R6", {31'd0, cmd_valid}, 32'd1);
    reg_read(2'd1, rv); chk("R2", rv, 32'h5);
    finish_cmd(8'h00);
    chk("R6", {31'd0, cmd_valid}, 32'd0);
    reg_read(2'd0, rv); chk("R9", rv, cw(3'd1, 6'd22, 2'd1, 8'hA5));
    reg_read(2'd1, rv); chk("R3", rv, 32'h4);
    mem_write(32'h10, 32'h10);
    chk("R9", {30'd0, cmd_valid, pt_wr}, 32'd0);
    // R5 second NOP raises cke
    run_cmd(3'd1, 6'd0, 2'd0, 8'd0, 8'd0, "R4");
    chk("R5", {30'd0, clk_en, cke}, 32'h3);
    // R4 decode corners
    run_cmd(3'd7, 6'd63, 2'd2, 8'h77, 8'd0, "R4");
    run_cmd(3'd7, 6'd10, 2'd3, 8'h77, 8'd0, "R4");
    run_cmd(3'd7, 6'd2, 2'd0, 8'h5A, 8'd0, "R4");
    run_cmd(3'd7, 6'd3, 2'd0, 8'h3C, 8'd0, "R4");
    run_cmd(3'd7, 6'd9, 2'd0, 8'hC3, 8'd0, "R4");
    run_cmd(3'd7, 6'd4, 2'd0, 8'h11, 8'h99, "R4");
    check_dev("R7");
    // R7 and R8 captures
    run_cmd(3'd7, 6'd5, 2'd0, 8'd0, 8'h11, "R7");
    run_cmd(3'd7, 6'd6, 2'd0, 8'd0, 8'h22, "R7");
    run_cmd(3'd7, 6'd8, 2'd0, 8'd0, 8'h33, "R7");
    check_dev("R7");
    run_cmd(3'd7, 6'd0, 2'd0, 8'd0, 8'h11, "R8");
    reg_read(2'd3, rv); chk("R8", rv, 32'h5);
    // R11 unsupported mode arms nothing and drops memory writes
    reg_write(2'd0, cw(3'd3, 6'd2, 2'd0, 8'h01));
    mem_write(32'h20, 32'h20);
    chk("R11", {30'd0, cmd_valid, pt_wr}, 32'd0);
    reg_read(2'd1, rv); chk("R11", rv, 32'hC);
    // R10 mode 0 cancels an armed command
    reg_write(2'd0, cw(3'd7, 6'd63, 2'd0, 8'h00));
    reg_write(2'd0, cw(3'd0, 6'd63, 2'd0, 8'h00));
    mem_write(32'h30, 32'h31);
    chk("R10", {30'd0, cmd_valid, pt_wr}, 32'h1);
    chk("R10", pt_wdata, 32'h31);
    // random commands
    for (int n = 0; n < 60; n++) begin
      logic [5:0] ma;
      logic [7:0] d, rb;
      logic [1:0] zq;
      ma = 6'($urandom_range(0, 63));
      d = 8'($urandom); rb = 8'($urandom); zq = 2'($urandom);
      if (n % 3 == 0) ma = 6'($urandom_range(4, 8));
      run_cmd(3'd7, ma, zq, d, rb, "R4");
    end
    check_dev("R7");
    reg_read(2'd3, rv); chk("R8", rv, {29'd0, m_info});
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule